// File: doc/BRIEF.md
# Programmable Asynchronous Serial Adapter

A byte-wide asynchronous transmitter and receiver sharing one small register window. A single register-select input picks between the control/status pair and the data pair. A write to the control side sets four things: the bit-clock divide, the character format, how RTS and the transmit interrupt behave (including a continuous break), and whether the receive interrupt is enabled. A read of the status side reports the line inputs, the holding-register states, the error flags and the interrupt request. Each direction has a single holding register and no deeper buffering.

The bit period is fixed by dividing the input clock by 1, 16 or 64. The fourth divide code does not set a rate. It puts the whole block into a master-reset state, and the block stays there until software writes a real divide code. The hardware reset input also leaves the block in master reset. The interrupt output is active high. It combines the receive-full and transmit-empty conditions, each gated by its own enable.

Top module: `async_serial_port`

## Requirements
- R1: While control bits [1:0] equal 3 (the state after rst_n), the receive-full, transmit-empty, framing, overrun, parity and interrupt flags read 0. txd stays high, writes to the transmit data register are dropped, and receiving is suspended. The block leaves this state only on a control write whose bits [1:0] are not 3.
- R2: Control bits [1:0] set the bit length. Code 0 gives 1 clock per bit, code 1 gives 16 clocks and code 2 gives 64 clocks.
- R3: Control bits [4:2] select the frame. Codes 0..7 mean 7E2, 7O2, 7E1, 7O1, 8N2, 8N1, 8E1, 8O1. A frame is a 0 start bit, then the data LSB first, then the parity bit if the format has one (even or odd over the data bits), then one or two stop bits at 1.
- R4: Control bits [6:5] select the transmit control. Code 0 gives RTS low with the TX interrupt disabled. Code 1 gives RTS low with the TX interrupt enabled. Code 2 gives RTS high with the TX interrupt disabled. Code 3 gives RTS low with the TX interrupt disabled and holds txd low as a break.
- R5: The status byte is laid out as follows: bit0 receive full, bit1 transmit empty, bit2 dcd_in, bit3 cts_in, bit4 framing error, bit5 overrun, bit6 parity error, bit7 interrupt request.
- R6: With sel=0, a write goes to control and a read returns status. With sel=1, a write goes to the transmit holding register and a read returns the received byte. In a 7-bit format, bit 7 of the received byte reads 0.
- R7: At divide 16 and 64 the receiver checks the start bit at its middle. A low pulse that is gone by that point is rejected and produces no character.
- R8: A received character sets the parity-error flag when its parity bit does not match. It sets the framing-error flag when the first stop bit is sampled low.
- R9: If a character completes while receive-full is still set, overrun is set and the earlier byte and its flags are kept.
- R10: Reading the data register (sel=1, rd_en) clears receive-full, overrun, framing error and parity error.
- R11: While cts_in is high, transmit-empty reads 0 and no new character is started. Clearing cts_in releases the pending character.
- R12: irq is 1 exactly when either (receive full and control bit 7 set) or (transmit empty and transmit control code 1) holds. The same value appears in status bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, enters master reset |
| sel | input | 1 | Register select: 0 control/status, 1 data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe, clears receive flags when sel=1 |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (status or received byte) |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input |
| rts_out | output | 1 | Request-to-send level |
| cts_in | input | 1 | Clear-to-send, high holds transmission off |
| dcd_in | input | 1 | Carrier detect, reported in status |
| irq | output | 1 | Interrupt request, active high |

## Verification
The assertions assume rxd keeps each bit stable for a whole bit period at the selected divide. They also assume the format and divide are not rewritten while a character is in flight, so the receiver's expected sampling points stay valid. The stimulus keeps to both. It drives every serial bit on falling clock edges for exactly the programmed number of clocks, and it reprograms control only once the line has gone idle. A handful of directed cases deliberately break these rules: a short low glitch, a corrupted parity bit and a low stop bit.

// File: rtl/async_serial_port.sv
module async_serial_port #(
  parameter int MID_DIV  = 16,
  parameter int SLOW_DIV = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       txd,
  input  logic       rxd,
  output logic       rts_out,
  input  logic       cts_in,
  input  logic       dcd_in,
  output logic       irq
);

  localparam int CW = $clog2(SLOW_DIV);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA} rx_state_t;

  logic [7:0] ctrl;
  logic [CW-1:0] bit_len_m1;

  wire [2:0] fmt      = ctrl[4:2];
  wire [1:0] txc      = ctrl[6:5];
  wire       mrst     = (ctrl[1:0] == 2'd3);
  wire       rie      = ctrl[7];
  wire       tie      = (txc == 2'd1);
  wire       brk      = (txc == 2'd3);
  wire       dbits8   = fmt[2];
  wire       has_par  = (fmt != 3'd4) && (fmt != 3'd5);
  wire       odd_par  = fmt[0];
  wire       two_stop = (fmt == 3'd0) || (fmt == 3'd1) || (fmt == 3'd4);
  wire [3:0] n_data   = dbits8 ? 4'd8 : 4'd7;

  assign rts_out = (txc == 2'd2);

  always_comb begin
    case (ctrl[1:0])
      2'd0:    bit_len_m1 = '0;
      2'd1:    bit_len_m1 = CW'(MID_DIV - 1);
      default: bit_len_m1 = CW'(SLOW_DIV - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                ctrl <= 8'h03;
    else if (wr_en && !sel)    ctrl <= wdata;

  // transmitter
  logic [7:0]    tdr;
  logic          tdr_full;
  logic [10:0]   tx_sr;
  logic [3:0]    tx_left;
  logic [CW-1:0] tx_div;
  logic [10:0]   tx_frame;
  logic [3:0]    tx_len;

  wire tx_busy = (tx_left != 4'd0);
  wire tx_go   = tdr_full && !tx_busy && !cts_in && !brk && !mrst;
  wire tdre    = !mrst && !tdr_full && !cts_in;

  always_comb begin
    tx_frame = '1;
    tx_frame[0] = 1'b0;
    if (dbits8) begin
      tx_frame[8:1] = tdr;
      if (has_par) tx_frame[9] = ^tdr ^ odd_par;
    end else begin
      tx_frame[7:1] = tdr[6:0];
      tx_frame[8]   = ^tdr[6:0] ^ odd_par;
    end
    tx_len = 4'd1 + n_data + {3'b000, has_par} + (two_stop ? 4'd2 : 4'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tdr      <= '0;
      tdr_full <= 1'b0;
      tx_sr    <= '1;
      tx_left  <= '0;
      tx_div   <= '0;
    end else if (mrst) begin
      tdr_full <= 1'b0;
      tx_sr    <= '1;
      tx_left  <= '0;
      tx_div   <= '0;
    end else begin
      if (tx_go) begin
        tx_sr    <= tx_frame;
        tx_left  <= tx_len;
        tx_div   <= bit_len_m1;
        tdr_full <= 1'b0;
      end else if (tx_busy) begin
        if (tx_div == '0) begin
          tx_sr   <= {1'b1, tx_sr[10:1]};
          tx_left <= tx_left - 4'd1;
          tx_div  <= bit_len_m1;
        end else begin
          tx_div <= tx_div - 1'b1;
        end
      end
      if (wr_en && sel) begin
        tdr      <= wdata;
        tdr_full <= 1'b1;
      end
    end
  end

  assign txd = mrst ? 1'b1 : (brk ? 1'b0 : tx_sr[0]);

  // receiver
  logic          rs1, rs2;
  rx_state_t     rx_st;
  logic [CW-1:0] rx_div;
  logic [3:0]    rx_cnt;
  logic [7:0]    rx_sh;
  logic          rx_pbit;
  logic [7:0]    rdr;
  logic          rdrf, ovrn, fe, pe;
  logic [7:0]    rx_byte;

  wire [3:0] rx_need = n_data + {3'b000, has_par} + 4'd1;
  wire       rx_tick = (rx_st == RX_DATA) && (rx_div == '0);
  wire       rx_done = rx_tick && (rx_cnt == rx_need - 4'd1);
  wire       rd_clr  = rd_en && sel;

  assign rx_byte = dbits8 ? rx_sh : {1'b0, rx_sh[6:0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rs1 <= 1'b1;
      rs2 <= 1'b1;
    end else begin
      rs1 <= rxd;
      rs2 <= rs1;
    end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_st <= RX_IDLE;
      rx_div <= '0;
      rx_cnt <= '0;
      rx_sh <= '0;
      rx_pbit <= 1'b0;
      rdr <= '0;
      {rdrf, ovrn, fe, pe} <= '0;
    end else if (mrst) begin
      rx_st <= RX_IDLE;
      rx_cnt <= '0;
      {rdrf, ovrn, fe, pe} <= '0;
    end else begin
      if (rd_clr) {rdrf, ovrn, fe, pe} <= '0;
      case (rx_st)
        RX_IDLE:
          if (!rs2) begin
            rx_cnt <= '0;
            if (bit_len_m1 == '0) begin
              rx_st  <= RX_DATA;
              rx_div <= '0;
            end else begin
              rx_st  <= RX_START;
              rx_div <= bit_len_m1 >> 1;
            end
          end
        RX_START:
          if (rx_div == '0) begin
            rx_st  <= rs2 ? RX_IDLE : RX_DATA;
            rx_div <= bit_len_m1;
          end else begin
            rx_div <= rx_div - 1'b1;
          end
        default:
          if (rx_tick) begin
            rx_div <= bit_len_m1;
            rx_cnt <= rx_cnt + 4'd1;
            if (rx_cnt < n_data)      rx_sh[rx_cnt[2:0]] <= rs2;
            else if (rx_cnt == n_data && has_par) rx_pbit <= rs2;
            if (rx_done) begin
              rx_st <= RX_IDLE;
              if (rdrf && !rd_clr) begin
                ovrn <= 1'b1;
              end else begin
                rdr  <= rx_byte;
                rdrf <= 1'b1;
                fe   <= !rs2;
                pe   <= has_par && (^rx_byte ^ rx_pbit ^ odd_par);
              end
            end
          end else begin
            rx_div <= rx_div - 1'b1;
          end
      endcase
    end
  end

  assign irq   = (rie && rdrf) || (tie && tdre);
  assign rdata = sel ? rdr : {irq, pe, ovrn, fe, cts_in, dcd_in, tdre, rdrf};

  AST_MRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    mrst |=> (!rdrf && !ovrn && !fe && !pe && !tdr_full && !tx_busy)); // R1
  AST_CTS_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_in && !tx_busy) |=> !tx_busy); // R11
  AST_OVR_KEEPS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (rdrf && rx_done && !rd_clr) |=> (ovrn && $stable(rdr))); // R9
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !rx_done) |=> (!rdrf && !ovrn && !fe && !pe)); // R10
  AST_LOAD_FROM_HOLDING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(tdr_full)); // R3

endmodule

// File: tb/async_serial_port_test.sv
`timescale 1ns/1ps
module async_serial_port_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic txd, rts_out, irq;
  logic rxd = 1'b1, cts_in = 1'b0, dcd_in = 1'b0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  async_serial_port uut (.clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .txd(txd), .rxd(rxd), .rts_out(rts_out),
    .cts_in(cts_in), .dcd_in(dcd_in), .irq(irq));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int div_of(input logic [1:0] c);
    return (c == 0) ? 1 : (c == 1) ? 16 : 64;
  endfunction
  function automatic int nd_of(input logic [2:0] f);
    return f[2] ? 8 : 7;
  endfunction
  function automatic bit par_of(input logic [2:0] f);
    return !(f == 4 || f == 5);
  endfunction
  function automatic int ns_of(input logic [2:0] f);
    return (f == 0 || f == 1 || f == 4) ? 2 : 1;
  endfunction
  function automatic int len_of(input logic [2:0] f);
    return 1 + nd_of(f) + int'(par_of(f)) + ns_of(f);
  endfunction
  function automatic logic [10:0] exp_frame(input logic [2:0] f, input logic [7:0] b);
    logic [10:0] v = '1;
    bit p = f[0];
    v[0] = 1'b0;
    for (int i = 0; i < nd_of(f); i++) begin
      v[1+i] = b[i];
      p ^= b[i];
    end
    if (par_of(f)) v[1+nd_of(f)] = p;
    return v;
  endfunction

  task automatic wr(input logic s, input logic [7:0] d);
    @(negedge clk); sel = s; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask
  task automatic rd_status(output logic [7:0] st);
    @(negedge clk); sel = 1'b0; #1 st = rdata;
  endtask
  task automatic rd_data(output logic [7:0] d);
    @(negedge clk); sel = 1'b1; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0; sel = 1'b0;
  endtask

  task automatic tx_check(input logic [2:0] f, input logic [1:0] c, input logic [7:0] b, input string req);
    int n = div_of(c);
    int len = len_of(f);
    int guard = 0;
    logic [10:0] got = '1;
    wr(1'b0, {3'b000, f, c});
    wr(1'b1, b);
    while (txd !== 1'b0 && guard < 400) begin @(negedge clk); guard++; end
    repeat (n / 2) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      got[i] = txd;
      repeat (n) @(negedge clk);
    end
    chk(req, int'(got), int'(exp_frame(f, b)));
    repeat (n + 2) @(negedge clk);
  endtask

  task automatic rx_send(input logic [2:0] f, input logic [1:0] c, input logic [7:0] b,
                         input bit flip_par, input bit bad_stop);
    int n = div_of(c);
    int len = len_of(f);
    logic [10:0] v = exp_frame(f, b);
    if (flip_par) v[1+nd_of(f)] = ~v[1+nd_of(f)];
    if (bad_stop) v[1+nd_of(f)+int'(par_of(f))] = 1'b0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk); rxd = v[i];
      repeat (n - 1) @(negedge clk);
    end
    @(negedge clk); rxd = 1'b1;
    repeat (2 * n + 6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] st, d, b;
    logic [2:0] f;
    logic [1:0] c;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    rd_status(st);
    chk("R1 reset status", st, 8'h00);
    chk("R1 reset txd", txd, 1);
    wr(1'b1, 8'h5A);
    repeat (4) @(negedge clk);
    chk("R1 data write ignored txd", txd, 1);
    wr(1'b0, 8'h15);               // 8N1, divide 16
    rd_status(st);
    chk("R1 exit master reset tdre R5", st, 8'h02);

    // directed and random transmit/receive frames
    for (int k = 0; k < 20; k++) begin
      f = (k < 8) ? 3'(k) : 3'($urandom % 8);
      c = (k % 5 == 4) ? 2'd2 : 2'($urandom % 2);
      b = 8'($urandom);
      tx_check(f, c, b, "R3 R2 tx frame");
      rx_send(f, c, b, 1'b0, 1'b0);
      rd_status(st);
      chk("R5 R8 rx status clean", st & 8'h71, 8'h01);
      rd_data(d);
      chk("R6 rx byte", d, nd_of(f) == 7 ? (b & 8'h7F) : b);
      rd_status(st);
      chk("R10 rdrf cleared", st[0], 0);
    end

    // divide-by-1 bit length
    tx_check(3'd5, 2'd0, 8'hC3, "R2 div1 frame");

    // parity error
    wr(1'b0, 8'h19);               // 8E1, /16
    rx_send(3'd6, 2'd1, 8'h3C, 1'b1, 1'b0);
    rd_status(st);
    chk("R8 parity error", st & 8'h71, 8'h41);
    rd_data(d);
    chk("R8 byte with parity error", d, 8'h3C);
    rd_status(st);
    chk("R10 pe cleared", st & 8'h71, 8'h00);

    // framing error
    wr(1'b0, 8'h15);               // 8N1, /16
    rx_send(3'd5, 2'd1, 8'hA5, 1'b0, 1'b1);
    rd_status(st);
    chk("R8 framing error", st & 8'h71, 8'h11);
    rd_data(d);
    rd_status(st);
    chk("R10 fe cleared", st & 8'h71, 8'h00);

    // false start rejection
    @(negedge clk); rxd = 1'b0;
    repeat (4) @(negedge clk); rxd = 1'b1;
    repeat (60) @(negedge clk);
    rd_status(st);
    chk("R7 glitch rejected", st[0], 0);

    // overrun
    rx_send(3'd5, 2'd1, 8'h11, 1'b0, 1'b0);
    rx_send(3'd5, 2'd1, 8'h22, 1'b0, 1'b0);
    rd_status(st);
    chk("R9 overrun set", st & 8'h21, 8'h21);
    rd_data(d);
    chk("R9 earlier byte kept", d, 8'h11);
    rd_status(st);
    chk("R10 overrun cleared", st & 8'h21, 8'h00);

    // CTS hold-off
    cts_in = 1'b1;
    wr(1'b1, 8'h96);
    repeat (40) @(negedge clk);
    rd_status(st);
    chk("R11 tdre low with cts", st & 8'h0A, 8'h08);
    chk("R11 txd idle with cts", txd, 1);
    cts_in = 1'b0;
    begin
      int guard = 0;
      while (txd !== 1'b0 && guard < 50) begin @(negedge clk); guard++; end
      chk("R11 released frame starts", txd, 0);
    end
    repeat (200) @(negedge clk);

    // RTS, break, DCD
    wr(1'b0, 8'h55);               // txc=2
    chk("R4 rts high", rts_out, 1);
    wr(1'b0, 8'h15);
    chk("R4 rts low", rts_out, 0);
    wr(1'b0, 8'h75);               // break
    repeat (30) @(negedge clk);
    chk("R4 break holds txd low", txd, 0);
    chk("R4 rts low in break", rts_out, 0);
    wr(1'b0, 8'h15);
    dcd_in = 1'b1;
    rd_status(st);
    chk("R5 dcd bit", st & 8'h0C, 8'h04);
    dcd_in = 1'b0;

    // interrupts
    wr(1'b0, 8'h35);               // tie on
    chk("R12 tx irq", irq, 1);
    cts_in = 1'b1;
    @(negedge clk);
    chk("R12 tx irq gated by cts", irq, 0);
    cts_in = 1'b0;
    wr(1'b0, 8'h95);               // rie on, tie off
    chk("R12 no irq without rx", irq, 0);
    rx_send(3'd5, 2'd1, 8'h7E, 1'b0, 1'b0);
    rd_status(st);
    chk("R12 rx irq in status", st[7], 1);
    chk("R12 rx irq pin", irq, 1);

    // master reset by control write
    wr(1'b0, 8'h03);
    rd_status(st);
    chk("R1 master reset clears", st, 8'h00);
    wr(1'b1, 8'hF0);
    wr(1'b0, 8'h01);               // 7E2 /16
    rd_status(st);
    chk("R1 dropped write leaves tdre", st, 8'h02);
    repeat (20) @(negedge clk);
    chk("R1 no frame after reset", txd, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule